// File: doc/BRIEF.md
# Lockable Sync and Conversion-Trigger Router

This block sits beside a group of PWM timers and capture units and decides where their synchronization pulses go. Software programs, through a small 32-bit register port, which source feeds the sync input of each of five downstream units: PWM units 4, 7 and 10 and capture units 1 and 4. It also picks which of four PWM sync outputs appears on the external sync pin. The sources are the sync outputs of PWM units 1, 4, 7 and 10, the sync output of capture unit 1, and two external sync inputs. A selection that would name the destination itself, or a unit further down the chain, is treated as a selection of source 0. This prevents sync loops.

A second register has one enable bit for each of twelve PWM start-of-conversion request lines on each of two channels, A and B. The enabled requests of a channel are merged. Each request that results drives that channel's active-low external trigger low for a fixed pulse length, which is 32 clock cycles by default. The pulse is produced by a two-state machine. In ST_IDLE the output is high. A merged request takes the transition IDLE_TO_LOW: the machine enters ST_LOW and loads the counter. In ST_LOW, a new request takes LOW_RELOAD and reloads the counter. The count reaching zero with no request takes LOW_TO_IDLE. Any other cycle in ST_LOW takes LOW_COUNT, which decrements the counter.

A third register holds two lock bits. Software can only set them, and only reset clears them. Each lock bit freezes one of the routing registers against writes, while reads stay available.

Top module: `syncroute_top`

## Requirements
- R1: After reset, every register reads 0, both trigger outputs are high (1), and every routed sync output follows source 0 (PWM unit 1 sync).
- R2: Registers sit at addr 0 (routing), 2 (trigger enables) and 4 (lock). Any other addr reads 0, and a write to it changes no register.
- R3: In the routing register, the destination selectors are at bits 2:0 (PWM unit 4), 5:3 (PWM unit 7), 8:6 (PWM unit 10), 11:9 (capture 1) and 14:12 (capture 4). The sync-pin selector is at bits 28:27. All other bits read 0.
- R4: Selector code 0..6 routes, in order: PWM1 sync, PWM4 sync, PWM7 sync, PWM10 sync, capture-1 sync, external sync 1, external sync 2.
- R5: Code 7 routes source 0. So does any code from (destination index + 1) to 4, with the destination indices PWM4=0, PWM7=1, PWM10=2, cap1=3, cap4=4.
- R6: Sync-pin selector codes 0..3 drive the pin from the sync of PWM unit 1, 4, 7 or 10.
- R7: In the trigger-enable register, bit n (0..11) enables channel-A request n, and bit 16+n enables channel-B request n. All other bits read 0.
- R8: A request on an enabled line, sampled at a clock edge, drives that channel's trigger output low from that edge for exactly 32 cycles. A request on a disabled line leaves the output high. The channels act independently.
- R9: A request that arrives while a pulse is running restarts the count, so the output stays low for 32 cycles after the last request.
- R10: Lock bit 0 protects the routing register and bit 1 protects the enable register. Writing 1 sets a bit, writing 0 leaves it unchanged, and only reset clears it. Bits 31:2 read 0.
- R11: A write to a locked register is ignored, and the register still reads back its held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | 4 | Register word offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data (combinational) |
| pwm_sync_i | input | 4 | Sync outputs of PWM units 1, 4, 7, 10 |
| cap_sync_i | input | 1 | Sync output of capture unit 1 |
| ext_sync_i | input | 2 | External sync inputs 1 and 2 |
| dest_sync_o | output | 5 | Routed syncs for PWM4, PWM7, PWM10, cap1, cap4 |
| sync_pin_o | output | 1 | External sync pin |
| soc_a_i | input | 12 | Channel-A conversion requests, PWM units 1..12 |
| soc_b_i | input | 12 | Channel-B conversion requests, PWM units 1..12 |
| trig_a_n_o | output | 1 | Active-low channel-A external trigger |
| trig_b_n_o | output | 1 | Active-low channel-B external trigger |

## Verification
Every selector code is written to all five destination fields at once. Each code is then tried with a one-hot pattern on each of the seven sources, so a swapped source index or a wrong reserved range shows as the wrong destination going high. Sync-pin codes are tried with one-hot PWM patterns in the same way. Trigger pulses are measured from a single request, from a request repeated mid-pulse (42 low cycles against 32 distinguishes a restart from an ignored request), from disabled lines, and on one channel while the other stays idle. Lock tests write 0 and 1 to the lock bits, then try to change locked and unlocked registers and read them back.

// File: rtl/syncroute_pkg.sv
package syncroute_pkg;
    localparam int ADDR_W   = 4;
    localparam int DATA_W   = 32;
    localparam int NUM_DEST = 5;
    localparam int SEL_W    = 3;
    localparam int NUM_SRC  = 7;
    localparam int NUM_PWM  = 12;
    localparam int OUT_W    = 2;
    localparam int PIN_LSB  = 27;
    localparam int B_LSB    = 16;

    localparam logic [ADDR_W-1:0] OFS_ROUTE = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_TRIG  = 4'h2;
    localparam logic [ADDR_W-1:0] OFS_LOCK  = 4'h4;

    typedef enum logic {ST_IDLE, ST_LOW} stretch_state_t;
endpackage

// File: rtl/syncroute_regs.sv
module syncroute_regs
    import syncroute_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          rdata,
    output logic [NUM_DEST*SEL_W-1:0]  route_sel,
    output logic [OUT_W-1:0]           pin_sel,
    output logic [NUM_PWM-1:0]         en_a,
    output logic [NUM_PWM-1:0]         en_b,
    output logic [1:0]                 lock
);
    localparam int RW = NUM_DEST * SEL_W;

    logic wr_route, wr_trig, wr_lock;

    assign wr_route = wr_en && (addr == OFS_ROUTE) && !lock[0];
    assign wr_trig  = wr_en && (addr == OFS_TRIG)  && !lock[1];
    assign wr_lock  = wr_en && (addr == OFS_LOCK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            route_sel <= '0;
            pin_sel   <= '0;
            en_a      <= '0;
            en_b      <= '0;
            lock      <= '0;
        end else begin
            if (wr_route) begin
                route_sel <= wdata[RW-1:0];
                pin_sel   <= wdata[PIN_LSB +: OUT_W];
            end
            if (wr_trig) begin
                en_a <= wdata[NUM_PWM-1:0];
                en_b <= wdata[B_LSB +: NUM_PWM];
            end
            if (wr_lock) begin
                lock <= lock | wdata[1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            OFS_ROUTE: begin
                rdata[RW-1:0]            = route_sel;
                rdata[PIN_LSB +: OUT_W]  = pin_sel;
            end
            OFS_TRIG: begin
                rdata[NUM_PWM-1:0]       = en_a;
                rdata[B_LSB +: NUM_PWM]  = en_b;
            end
            OFS_LOCK:  rdata[1:0] = lock;
            default:   rdata = '0;
        endcase
    end

    // Lock bits only ever rise until reset
    assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lock[0] |=> lock[0]);
    assert_lock1_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lock[1] |=> lock[1]);
    assert_route_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        lock[0] |=> ($stable(route_sel) && $stable(pin_sel)));
    assert_trig_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        lock[1] |=> ($stable(en_a) && $stable(en_b)));
endmodule

// File: rtl/syncroute_mux.sv
module syncroute_mux
    import syncroute_pkg::*;
#(
    parameter int DEST_IDX = 0
) (
    input  logic [SEL_W-1:0]   sel,
    input  logic [NUM_SRC-1:0] src,
    output logic               sync_o
);
    localparam int LAST_CHAIN = 4;
    localparam int TOP_CODE   = (1 << SEL_W) - 1;

    logic [SEL_W-1:0] eff;

    always_comb begin
        if ((int'(sel) == TOP_CODE) ||
            ((int'(sel) > DEST_IDX) && (int'(sel) <= LAST_CHAIN)))
            eff = '0;
        else
            eff = sel;
    end

    assign sync_o = src[eff];
endmodule

// File: rtl/syncroute_stretch.sv
module syncroute_stretch
    import syncroute_pkg::*;
#(
    parameter int PULSE_LEN = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic trig_n
);
    localparam int CNT_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_LEN - 1);

    stretch_state_t state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_IDLE: if (req) begin            // IDLE_TO_LOW
                state_nx = ST_LOW;
                cnt_nx   = LOAD;
            end
            ST_LOW: begin
                if (req) cnt_nx = LOAD;          // LOW_RELOAD
                else if (cnt == '0) state_nx = ST_IDLE; // LOW_TO_IDLE
                else cnt_nx = cnt - 1'b1;        // LOW_COUNT
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        trig_n = (state != ST_LOW);
    end

    assert_pulse_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !trig_n);
    assert_pulse_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(req) == 1'b0 && $past(state) == ST_LOW && $past(cnt) != '0) |-> !trig_n);
endmodule

// File: rtl/syncroute_top.sv
module syncroute_top
    import syncroute_pkg::*;
#(
    parameter int PULSE_LEN = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [3:0]           addr,
    input  logic [31:0]          wdata,
    output logic [31:0]          rdata,
    input  logic [3:0]           pwm_sync_i,
    input  logic                 cap_sync_i,
    input  logic [1:0]           ext_sync_i,
    output logic [4:0]           dest_sync_o,
    output logic                 sync_pin_o,
    input  logic [11:0]          soc_a_i,
    input  logic [11:0]          soc_b_i,
    output logic                 trig_a_n_o,
    output logic                 trig_b_n_o
);
    logic [NUM_DEST*SEL_W-1:0] route_sel;
    logic [OUT_W-1:0]          pin_sel;
    logic [NUM_PWM-1:0]        en_a, en_b;
    logic [1:0]                lock;
    logic [NUM_SRC-1:0]        src;

    assign src = {ext_sync_i, cap_sync_i, pwm_sync_i};

    syncroute_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .route_sel(route_sel),
        .pin_sel(pin_sel), .en_a(en_a), .en_b(en_b), .lock(lock)
    );

    for (genvar d = 0; d < NUM_DEST; d++) begin : g_dest
        syncroute_mux #(.DEST_IDX(d)) u_mux (
            .sel(route_sel[d*SEL_W +: SEL_W]),
            .src(src),
            .sync_o(dest_sync_o[d])
        );
    end

    assign sync_pin_o = pwm_sync_i[pin_sel];

    syncroute_stretch #(.PULSE_LEN(PULSE_LEN)) u_str_a (
        .clk(clk), .rst_n(rst_n), .req(|(soc_a_i & en_a)), .trig_n(trig_a_n_o)
    );
    syncroute_stretch #(.PULSE_LEN(PULSE_LEN)) u_str_b (
        .clk(clk), .rst_n(rst_n), .req(|(soc_b_i & en_b)), .trig_n(trig_b_n_o)
    );
endmodule

// File: tb/syncroute_top_test.sv
module syncroute_top_test;
    localparam int CLK_P = 10;

    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [3:0] addr = '0;
    logic [31:0] wdata = '0, rdata;
    logic [3:0] pwm_sync_i = '0;
    logic cap_sync_i = 1'b0;
    logic [1:0] ext_sync_i = '0;
    logic [4:0] dest_sync_o;
    logic sync_pin_o;
    logic [11:0] soc_a_i = '0, soc_b_i = '0;
    logic trig_a_n_o, trig_b_n_o;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    syncroute_top uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
        addr = a; #1;
        chk(req, rdata, exp);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    function automatic logic exp_route(input int d, input int code, input logic [6:0] s);
        int c = code;
        if (c == 7 || (c > d && c <= 4)) c = 0;
        return s[c];
    endfunction

    task automatic set_src(input logic [6:0] s);
        pwm_sync_i = s[3:0]; cap_sync_i = s[4]; ext_sync_i = s[6:5]; #1;
    endtask

    task automatic t_reset();
        rd_chk("R1 route reset", 4'h0, 32'h0);
        rd_chk("R1 trig reset", 4'h2, 32'h0);
        rd_chk("R1 lock reset", 4'h4, 32'h0);
        chk("R1 trig A idle", trig_a_n_o, 1'b1);
        chk("R1 trig B idle", trig_b_n_o, 1'b1);
        set_src(7'b0000001);
        chk("R1 dests follow src0", dest_sync_o, 5'b11111);
        set_src(7'b1111110);
        chk("R1 dests ignore others", dest_sync_o, 5'b00000);
        set_src(7'b0);
    endtask

    task automatic t_map();
        wr(4'h0, 32'hFFFF_FFFF);
        rd_chk("R3 route mask", 4'h0, 32'h1800_7FFF);
        wr(4'h2, 32'hFFFF_FFFF);
        rd_chk("R7 trig mask", 4'h2, 32'h0FFF_0FFF);
        wr(4'h6, 32'h0);
        rd_chk("R2 reserved read", 4'h6, 32'h0);
        rd_chk("R2 route untouched", 4'h0, 32'h1800_7FFF);
        rd_chk("R2 trig untouched", 4'h2, 32'h0FFF_0FFF);
        wr(4'h0, 32'h0000_2A1D);
        rd_chk("R3 field layout", 4'h0, 32'h0000_2A1D);
    endtask

    task automatic t_route();
        for (int c = 0; c < 8; c++) begin
            logic [2:0] cc = 3'(c);
            wr(4'h0, {17'b0, cc, cc, cc, cc, cc});
            for (int s = 0; s < 7; s++) begin
                logic [6:0] pat = 7'(1 << s);
                logic [4:0] e;
                set_src(pat);
                for (int d = 0; d < 5; d++) e[d] = exp_route(d, c, pat);
                chk((c == 7 || c <= 4) ? "R5 reserved substitution" : "R4 route code",
                    dest_sync_o, e);
            end
        end
        set_src(7'b0);
    endtask

    task automatic t_pin();
        for (int c = 0; c < 4; c++) begin
            wr(4'h0, 32'(c) << 27);
            for (int s = 0; s < 4; s++) begin
                pwm_sync_i = 4'(1 << s); #1;
                chk("R6 sync pin", sync_pin_o, (s == c));
            end
        end
        pwm_sync_i = '0;
    endtask

    task automatic pulse_len(input bit chan_b, input int gap, output int low);
        @(negedge clk);
        if (chan_b) soc_b_i = 12'h800; else soc_a_i = 12'h001;
        @(negedge clk);
        soc_a_i = '0; soc_b_i = '0;
        low = 0;
        while (((chan_b ? trig_b_n_o : trig_a_n_o) == 1'b0) && low < 200) begin
            if (gap > 0 && low == gap) begin
                if (chan_b) soc_b_i = 12'h800; else soc_a_i = 12'h001;
            end else begin
                soc_a_i = '0; soc_b_i = '0;
            end
            low++;
            @(negedge clk);
        end
        soc_a_i = '0; soc_b_i = '0;
    endtask

    task automatic t_pulse();
        int n;
        wr(4'h2, 32'h0800_0001);
        pulse_len(1'b0, 0, n);
        chk("R8 channel A width", 32'(n), 32'd32);
        pulse_len(1'b1, 0, n);
        chk("R8 channel B width", 32'(n), 32'd32);
        pulse_len(1'b0, 9, n);
        chk("R9 channel A retrigger", 32'(n), 32'd42);
        pulse_len(1'b1, 9, n);
        chk("R9 channel B retrigger", 32'(n), 32'd42);
        @(negedge clk);
        soc_a_i = 12'h001; #1;
        @(negedge clk);
        soc_a_i = '0;
        chk("R8 B unaffected by A", trig_b_n_o, 1'b1);
        chk("R8 A low", trig_a_n_o, 1'b0);
        repeat (40) @(negedge clk);
        soc_a_i = 12'hFFE; soc_b_i = 12'h7FF;
        @(negedge clk);
        soc_a_i = '0; soc_b_i = '0;
        @(negedge clk);
        chk("R8 disabled A lines", trig_a_n_o, 1'b1);
        chk("R8 disabled B lines", trig_b_n_o, 1'b1);
    endtask

    task automatic t_lock();
        wr(4'h0, 32'h0800_0123);
        wr(4'h2, 32'h0000_0005);
        wr(4'h4, 32'hFFFF_FFFC);
        rd_chk("R10 upper lock bits", 4'h4, 32'h0);
        wr(4'h4, 32'h1);
        rd_chk("R10 lock0 set", 4'h4, 32'h1);
        wr(4'h4, 32'h0);
        rd_chk("R10 write 0 no clear", 4'h4, 32'h1);
        wr(4'h0, 32'h1000_4000);
        rd_chk("R11 route frozen", 4'h0, 32'h0800_0123);
        wr(4'h2, 32'h0003_0003);
        rd_chk("R11 trig still writable", 4'h2, 32'h0003_0003);
        wr(4'h4, 32'h2);
        rd_chk("R10 both locked", 4'h4, 32'h3);
        wr(4'h2, 32'h0);
        rd_chk("R11 trig frozen", 4'h2, 32'h0003_0003);
        do_reset();
        rd_chk("R10 reset clears lock", 4'h4, 32'h0);
        wr(4'h0, 32'h0000_0007);
        rd_chk("R10 route writable after reset", 4'h0, 32'h0000_0007);
    endtask

    initial begin
        do_reset();
        t_reset();
        t_map();
        t_route();
        t_pin();
        t_pulse();
        t_lock();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule